// File: doc/BRIEF.md
# Timing Error Rate Monitor and Classifier

This block watches the per-cycle timing-error flag raised by a functional unit's error-detection sensors. It counts how many of the unit's active cycles carried an error over a window whose length is programmable. When the window closes, it turns the error fraction into one of four rate classes. Software polls a small read-only register space to fetch the class and the raw count, and a runtime scheduler can use these to decide which units get which work.

The class boundaries sit at one third and two thirds of the window. They are evaluated by comparing three times the error count with the window length, so no divider is needed. Any result the monitor cannot trust is reported as the highest class, so a unit in doubt is treated as the worst case. A window length of zero switches the monitor off.

Top module: `ter_monitor`

## Requirements
- R1: After reset the class is 3 (high), the reported count is 0 and the valid bit is 0.
- R2: Over one window, exactly `win_len` cycles with `active`=1 are counted, and an error is tallied only in those cycles. Cycles with `active`=0 neither advance the window nor add errors, whatever `err_flag` is.
- R3: Class encoding, with e errors in a window of W cycles: 0 when e=0; 1 (low) when 0 < 3e <= W; 2 (medium) when W < 3e <= 2W; 3 (high) when 3e > 2W.
- R4: The boundaries go to the lower class. 3e equal to W gives class 1, and 3e equal to 2W gives class 2.
- R5: The class and count registers change together, only at the clock edge that ends a window. Between such edges they hold their values, including while the next window is in progress.
- R6: The valid bit is set when a window ends and stays set until the status register (address 0) is read. Reading address 1 leaves it set. If a status read and a window end happen in the same cycle, that read returns the old valid value and the bit ends up set.
- R7: While `win_len` is 0 the monitor is off. The class is held at 3, the partial window is discarded, the valid bit is not set, and counting starts fresh once a nonzero length is applied.
- R8: The length is captured at the first active cycle of each window. If `win_len` differs from the captured value at any point before that window ends, the window still ends after the captured length, but its class is forced to 3. The count is still reported.
- R9: Register map: address 0 returns the class in bits [1:0] and valid in bit 8; address 1 returns the count in bits [15:0]; other addresses return 0. Unused bits read 0. `rd_data` is updated on the edge where `rd_en` is sampled high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | The unit did work this cycle; the cycle counts toward the window |
| err_flag | input | 1 | A timing error was reported this cycle |
| win_len | input | 16 | Window length in active cycles; 0 disables the monitor |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register address |
| rd_data | output | 32 | Registered read data |

## Verification
The class, count and valid bit change on the same edge that samples the last active cycle of a window. They can only be seen through a read, whose data appears on the edge that samples `rd_en`. The bench therefore drives on falling edges, lets at least one full cycle pass after the last active cycle, and samples `rd_data` on the falling edge right after the read strobe. For the case where a read and a window end coincide, it samples that same falling edge and expects the pre-update valid value, then expects the set value on the next read.

// File: rtl/ter_monitor.sv
module ter_monitor #(
  parameter int WIN_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              err_flag,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int MW = ((CNT_W > WIN_W) ? CNT_W : WIN_W) + 2;

  logic [WIN_W-1:0] cyc_cnt, win_q;
  logic [CNT_W-1:0] err_cnt, count_q;
  logic [1:0]       class_q, class_new;
  logic             valid_q, dirty_q;

  wire              enabled   = (win_len != '0);
  wire              first     = (cyc_cnt == '0);
  wire [WIN_W-1:0]  eff_len   = first ? win_len : win_q;
  wire              dirty_now = dirty_q | (!first && (win_len != win_q));
  wire              pub       = enabled && active && (cyc_cnt == eff_len - WIN_W'(1));
  wire [CNT_W-1:0]  err_next  = (err_flag && !(&err_cnt)) ? err_cnt + CNT_W'(1) : err_cnt;

  wire [MW-1:0] e3 = MW'(err_next) + MW'({err_next, 1'b0});
  wire [MW-1:0] w1 = MW'(eff_len);
  wire [MW-1:0] w2 = MW'({eff_len, 1'b0});

  always_comb begin
    if (dirty_now || (&err_next)) class_new = 2'd3;
    else if (err_next == '0)      class_new = 2'd0;
    else if (e3 <= w1)            class_new = 2'd1;
    else if (e3 <= w2)            class_new = 2'd2;
    else                          class_new = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      win_q   <= '0;
      err_cnt <= '0;
      dirty_q <= 1'b0;
      count_q <= '0;
      class_q <= 2'd3;
    end else if (!enabled) begin
      cyc_cnt <= '0;
      err_cnt <= '0;
      dirty_q <= 1'b0;
      class_q <= 2'd3;
    end else if (active && pub) begin
      cyc_cnt <= '0;
      err_cnt <= '0;
      dirty_q <= 1'b0;
      count_q <= err_next;
      class_q <= class_new;
    end else if (active) begin
      cyc_cnt <= cyc_cnt + WIN_W'(1);
      err_cnt <= err_next;
      dirty_q <= dirty_now;
      if (first) win_q <= win_len;
    end else begin
      dirty_q <= dirty_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            valid_q <= 1'b0;
    else if (pub)                          valid_q <= 1'b1;
    else if (rd_en && rd_addr == 2'd0)     valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        2'd0:    rd_data <= DATA_W'({valid_q, 6'd0, class_q});
        2'd1:    rd_data <= DATA_W'(count_q);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ter_monitor_chk.sv
module ter_monitor_chk #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic [WIN_W-1:0] win_len,
  input logic [WIN_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] err_cnt,
  input logic [CNT_W-1:0] count_q,
  input logic [1:0]       class_q,
  input logic             valid_q,
  input logic             pub,
  input logic             dirty_now
);
  p_err_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (WIN_W'(err_cnt) <= cyc_cnt));

  p_zero_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pub && !dirty_now) |=> ((class_q == 2'd0) == (count_q == '0)));

  p_hold_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pub && win_len != '0) |=> $stable(class_q) && $stable(count_q));

  p_pub_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pub |=> valid_q);

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd0 && !pub) |=> !valid_q);

  p_off_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == '0) |=> (class_q == 2'd3) && (cyc_cnt == '0) && !pub);

  p_dirty_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pub && dirty_now) |=> (class_q == 2'd3));
endmodule

bind ter_monitor ter_monitor_chk #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ter_monitor_tb.sv
`timescale 1ns/1ps
module ter_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        active = 1'b0;
  logic        err_flag = 1'b0;
  logic [15:0] win_len = 16'd0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ter_monitor u_dut (.*);

  function automatic int exp_class(int e, int w);
    if (e == 0) return 0;
    if (3 * e <= w) return 1;
    if (3 * e <= 2 * w) return 2;
    return 3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic run_win(input int len, input int pct, input bit idles, output int e);
    e = 0;
    for (int i = 0; i < len; i++) begin
      while (idles && ($urandom % 4 == 0)) begin
        @(negedge clk); active = 1'b0; err_flag = 1'($urandom % 2);
        @(posedge clk);
      end
      @(negedge clk); active = 1'b1; err_flag = 1'(($urandom % 100) < pct);
      if (err_flag) e++;
      @(posedge clk);
    end
    @(negedge clk); active = 1'b0; err_flag = 1'b0;
  endtask

  task automatic check_win(input string req, input int e, input int cls);
    logic [31:0] d;
    rd(2'd1, d); chk({req, " count"}, d, 32'(e));
    rd(2'd0, d); chk({req, " status"}, d, {23'd0, 1'b1, 6'd0, 2'(cls)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e, len, pct;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    rd(2'd0, d); chk("R1 status after reset", d, 32'h3);
    rd(2'd1, d); chk("R1 count after reset", d, 32'h0);
    rd(2'd2, d); chk("R9 unmapped address", d, 32'h0);

    win_len = 16'd3;
    run_win(3, 0, 1'b0, e); check_win("R3 zero errors", e, 0);
    run_win(3, 0, 1'b0, e);
    run_win(0, 0, 1'b0, e);
    @(negedge clk); active = 1'b1; err_flag = 1'b1; @(posedge clk);
    @(negedge clk); active = 1'b0; err_flag = 1'b0;
    rd(2'd1, d); chk("R5 count held before window end", d, 32'h0);
    run_win(2, 0, 1'b0, e); check_win("R4 3e==W is low", 1, 1);
    @(negedge clk); active = 1'b1; err_flag = 1'b1; @(posedge clk);
    @(negedge clk); err_flag = 1'b1; @(posedge clk);
    @(negedge clk); err_flag = 1'b0; @(posedge clk);
    @(negedge clk); active = 1'b0;
    check_win("R4 3e==2W is medium", 2, 2);
    run_win(3, 100, 1'b0, e); check_win("R3 all errors high", e, 3);

    win_len = 16'd1;
    run_win(1, 100, 1'b0, e); check_win("R3 single-cycle window", e, 3);

    win_len = 16'd6;
    run_win(6, 100, 1'b0, e);
    rd(2'd1, d); chk("R6 count read keeps valid", d, 32'd6);
    rd(2'd0, d); chk("R6 valid seen", d[8], 1'b1);
    rd(2'd0, d); chk("R6 valid cleared by status read", d, 32'h3);

    win_len = 16'd4;
    run_win(3, 0, 1'b0, e);
    @(negedge clk); active = 1'b1; err_flag = 1'b0; rd_en = 1'b1; rd_addr = 2'd0;
    @(posedge clk);
    @(negedge clk); active = 1'b0; rd_en = 1'b0;
    chk("R6 same-cycle read returns old valid", rd_data[8], 1'b0);
    rd(2'd0, d); chk("R6 window end wins over clear", d, 32'h100);

    win_len = 16'd8;
    run_win(3, 100, 1'b0, e);
    @(negedge clk); win_len = 16'd0;
    repeat (3) @(posedge clk);
    rd(2'd0, d); chk("R7 disabled holds high without valid", d, 32'h3);
    win_len = 16'd8;
    run_win(8, 0, 1'b0, e);
    check_win("R7 partial window discarded", 0, 0);

    win_len = 16'd10;
    run_win(4, 50, 1'b0, e);
    @(negedge clk); win_len = 16'd12;
    run_win(6, 0, 1'b0, len);
    check_win("R8 length change forces high", e, 3);
    run_win(12, 0, 1'b0, e);
    check_win("R8 next window clean", 0, 0);

    for (int k = 0; k < 40; k++) begin
      len = 1 + int'($urandom % 30);
      pct = int'($urandom % 101);
      win_len = 16'(len);
      run_win(len, pct, 1'b1, e);
      check_win($sformatf("R2 R3 random window %0d len %0d", k, len), e, exp_class(e, len));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule